// File: doc/BRIEF.md
# System control register bank

A word-addressed bank of 32 registers that collects the small system-control functions of a chip: a general-purpose pin group (synchronised inputs, driven outputs and an interrupt-enable mask), a configuration-port command word, a scratch word for debug software with a sticky lock flag, and fixed read-only words for the clock frequency, the capability flags and the system identity. The bus side is a plain 32-bit read/write port with a byte address. The two low address bits are dropped, so the register index is the byte address divided by four.

Two registers have side effects and do not store anything. A write to the identity word leaves its value unchanged but raises a one-cycle system reset request. A write to the configuration-port command word raises a one-cycle shutdown request when its low half-word holds the shutdown command. Any access to an index that holds no register returns zero, changes nothing and pulses an error flag for one cycle.

Top module: `sys_ctrl_bank`

## Requirements
- R1: After reset the bank reads: pin inputs = STRAP, pin outputs 0, interrupt enable 0, command word 0x00000001 (bit 0 = ready), scratch 0, lock 0, clock word CLK_HZ (default 80000000), capability word CAPS, identity word SYS_ID (default 0x10014D31); gpio_out_o, bus_err_o and both request outputs are low.
- R2: Read data for an access with bus_rd_i high appears on bus_rdata_o after the next rising edge and holds until the next read; the index is bus_addr_i[6:2] and bus_addr_i[1:0] is ignored. Index map: 0 pin inputs, 1 pin outputs, 2 interrupt enable, 16 command, 20 scratch, 21 lock, 29 clock, 30 capabilities, 31 identity.
- R3: Pin outputs (index 1, low GPIO_W bits), interrupt enable (index 2, low GPIO_W bits) and scratch (index 20, 32 bits) store written data; gpio_out_o shows the stored pin outputs from the edge that takes the write.
- R4: Any write to the lock word (index 21) makes it read 1, whatever the data, and it stays 1 until reset.
- R5: A write to the identity word leaves its value unchanged and drives sys_rst_req_o high for exactly the one cycle after the write edge.
- R6: A write to the command word whose bits [15:0] equal 0x000E drives shutdown_req_o high for the one cycle after the write edge, whatever bits [31:16] hold; any other value raises nothing; the command word always reads 0x00000001.
- R7: Writes to the pin-input, clock and capability words are ignored and raise no error.
- R8: Reads of an index with no register return 0; writes to one change nothing; either access drives bus_err_o high for the cycle after the access edge. Mapped accesses leave it low.
- R9: The pin-input word follows gpio_in_i through two flops: a value applied before edge k is seen by a read whose access edge is k+2 or later, and not by one at edge k+1.
- R10: Request outputs never pulse without a write to their register; reads raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 7 | Byte address; bits [6:2] select the register |
| bus_wr_i | input | 1 | Write strobe, one access per cycle |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_err_o | output | 1 | One-cycle pulse after an access to an unmapped index |
| gpio_in_i | input | GPIO_W | Asynchronous pin inputs |
| gpio_out_o | output | GPIO_W | Pin output register |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| shutdown_req_o | output | 1 | One-cycle shutdown request |

## Verification
Every result of an access is due exactly one rising edge after the edge that takes it: read data, the error flag, both requests and the pin outputs. The bench drives each access on a falling edge and samples the outputs at the following falling edge, then checks the pulses low one cycle later. The pin-input path is the only two-edge path, so the bench checks it with back-to-back reads and expects the old value at the second access edge after a pin change and the new value at the third.

// File: rtl/sysc_pkg.sv
package sysc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned NUM_WORDS = 32;
  localparam int unsigned IDX_W = $clog2(NUM_WORDS);
  localparam int unsigned ADDR_W = IDX_W + 2;

  // Fixed map: software decodes these indices
  localparam logic [IDX_W-1:0] IDX_PIN_IN  = 5'd0;
  localparam logic [IDX_W-1:0] IDX_PIN_OUT = 5'd1;
  localparam logic [IDX_W-1:0] IDX_PIN_IE  = 5'd2;
  localparam logic [IDX_W-1:0] IDX_CMD     = 5'd16;
  localparam logic [IDX_W-1:0] IDX_SCRATCH = 5'd20;
  localparam logic [IDX_W-1:0] IDX_LOCK    = 5'd21;
  localparam logic [IDX_W-1:0] IDX_CLK_HZ  = 5'd29;
  localparam logic [IDX_W-1:0] IDX_CAPS    = 5'd30;
  localparam logic [IDX_W-1:0] IDX_SYS_ID  = 5'd31;

  localparam logic [15:0] CMD_SHUTDOWN = 16'h000E;
  localparam logic [WORD_W-1:0] CMD_READY_WORD = 32'h0000_0001;

  typedef struct packed {
    logic pin_in;
    logic pin_out;
    logic pin_ie;
    logic cmd;
    logic scratch;
    logic lock;
    logic clk_hz;
    logic caps;
    logic sys_id;
  } sel_t;

  function automatic logic idx_mapped(input logic [IDX_W-1:0] idx);
    return idx inside {IDX_PIN_IN, IDX_PIN_OUT, IDX_PIN_IE, IDX_CMD, IDX_SCRATCH,
                       IDX_LOCK, IDX_CLK_HZ, IDX_CAPS, IDX_SYS_ID};
  endfunction
endpackage

// File: rtl/sysc_decode.sv
module sysc_decode
  import sysc_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output sel_t             sel_o,
  output logic             mapped_o
);
  always_comb begin
    sel_o = '0;
    unique case (idx_i)
      IDX_PIN_IN:  sel_o.pin_in  = 1'b1;
      IDX_PIN_OUT: sel_o.pin_out = 1'b1;
      IDX_PIN_IE:  sel_o.pin_ie  = 1'b1;
      IDX_CMD:     sel_o.cmd     = 1'b1;
      IDX_SCRATCH: sel_o.scratch = 1'b1;
      IDX_LOCK:    sel_o.lock    = 1'b1;
      IDX_CLK_HZ:  sel_o.clk_hz  = 1'b1;
      IDX_CAPS:    sel_o.caps    = 1'b1;
      IDX_SYS_ID:  sel_o.sys_id  = 1'b1;
      default:     sel_o = '0;
    endcase
    mapped_o = |sel_o;
  end
endmodule

// File: rtl/sysc_sync.sv
module sysc_sync #(
  parameter int unsigned        W       = 32,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, stab_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[b];
        stab_q <= RST_VAL[b];
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end
endmodule

// File: rtl/sysc_req_gen.sv
module sysc_req_gen
  import sysc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic        hit_sys_id_i,
  input  logic        hit_cmd_i,
  input  logic [15:0] cmd_i,
  output logic        rst_req_o,
  output logic        shut_req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_req_o  <= 1'b0;
      shut_req_o <= 1'b0;
    end else begin
      rst_req_o  <= wr_i && hit_sys_id_i;
      shut_req_o <= wr_i && hit_cmd_i && (cmd_i == CMD_SHUTDOWN);
    end
  end
endmodule

// File: rtl/sys_ctrl_bank.sv
module sys_ctrl_bank
  import sysc_pkg::*;
#(
  parameter int unsigned         GPIO_W = 32,
  parameter logic [GPIO_W-1:0]   STRAP  = 1,
  parameter logic [WORD_W-1:0]   CLK_HZ = 32'd80_000_000,
  parameter logic [WORD_W-1:0]   CAPS   = 32'h0000_0000,
  parameter logic [WORD_W-1:0]   SYS_ID = 32'h1001_4D31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  input  logic [GPIO_W-1:0] gpio_in_i,
  output logic [GPIO_W-1:0] gpio_out_o,
  output logic              sys_rst_req_o,
  output logic              shutdown_req_o
);
  logic [IDX_W-1:0]  idx;
  logic [1:0]        unused_lsb;
  sel_t              sel;
  logic              mapped;
  logic [GPIO_W-1:0] pin_in, pin_out_q, pin_ie_q;
  logic [WORD_W-1:0] scratch_q, rd_word, rdata_q;
  logic              lock_q, err_q;

  assign idx        = bus_addr_i[ADDR_W-1:2];
  assign unused_lsb = bus_addr_i[1:0];

  sysc_decode u_decode (
    .idx_i    (idx),
    .sel_o    (sel),
    .mapped_o (mapped)
  );

  sysc_sync #(.W(GPIO_W), .RST_VAL(STRAP)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (gpio_in_i),
    .sync_o  (pin_in)
  );

  sysc_req_gen u_req (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (bus_wr_i),
    .hit_sys_id_i (sel.sys_id),
    .hit_cmd_i    (sel.cmd),
    .cmd_i        (bus_wdata_i[15:0]),
    .rst_req_o    (sys_rst_req_o),
    .shut_req_o   (shutdown_req_o)
  );

  // Storage; read-only and side-effect words hold nothing
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_out_q <= '0;
      pin_ie_q  <= '0;
      scratch_q <= '0;
      lock_q    <= 1'b0;
    end else if (bus_wr_i) begin
      if (sel.pin_out) pin_out_q <= bus_wdata_i[GPIO_W-1:0];
      if (sel.pin_ie)  pin_ie_q  <= bus_wdata_i[GPIO_W-1:0];
      if (sel.scratch) scratch_q <= bus_wdata_i;
      if (sel.lock)    lock_q    <= 1'b1;
    end
  end

  always_comb begin
    rd_word = '0;
    unique case (1'b1)
      sel.pin_in:  rd_word[GPIO_W-1:0] = pin_in;
      sel.pin_out: rd_word[GPIO_W-1:0] = pin_out_q;
      sel.pin_ie:  rd_word[GPIO_W-1:0] = pin_ie_q;
      sel.cmd:     rd_word = CMD_READY_WORD;
      sel.scratch: rd_word = scratch_q;
      sel.lock:    rd_word[0] = lock_q;
      sel.clk_hz:  rd_word = CLK_HZ;
      sel.caps:    rd_word = CAPS;
      sel.sys_id:  rd_word = SYS_ID;
      default:     rd_word = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (bus_rd_i) rdata_q <= rd_word;
      err_q <= (bus_rd_i || bus_wr_i) && !mapped;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_err_o   = err_q;
  assign gpio_out_o  = pin_out_q;
endmodule

// File: rtl/sysc_chk.sv
module sysc_chk
  import sysc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  idx_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [15:0]       cmd_i,
  input logic [WORD_W-1:0] rdata_i,
  input logic              err_i,
  input logic              rst_req_i,
  input logic              shut_req_i
);
  logic lock_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_seen_q <= 1'b0;
    else if (wr_i && idx_i == IDX_LOCK) lock_seen_q <= 1'b1;
  end

  a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == IDX_LOCK && lock_seen_q) |=> (rdata_i == 32'd1));

  a_r5_rst_req_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && idx_i == IDX_SYS_ID) |=> rst_req_i);

  a_r10_rst_req_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(wr_i && idx_i == IDX_SYS_ID));

  a_r6_shut_req_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shut_req_i |-> $past(wr_i && idx_i == IDX_CMD && cmd_i == CMD_SHUTDOWN));

  a_r6_cmd_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && idx_i == IDX_CMD) |=> (rdata_i == CMD_READY_WORD));

  a_r8_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !idx_mapped(idx_i)) |=> (rdata_i == '0));

  a_r8_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_i || wr_i) && !idx_mapped(idx_i)) |=> err_i);

  a_r8_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> $past((rd_i || wr_i) && !idx_mapped(idx_i)));
endmodule

bind sys_ctrl_bank sysc_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .idx_i      (bus_addr_i[6:2]),
  .wr_i       (bus_wr_i),
  .rd_i       (bus_rd_i),
  .cmd_i      (bus_wdata_i[15:0]),
  .rdata_i    (bus_rdata_o),
  .err_i      (bus_err_o),
  .rst_req_i  (sys_rst_req_o),
  .shut_req_i (shutdown_req_o)
);

// File: tb/sys_ctrl_bank_tb.sv
module sys_ctrl_bank_tb_top;
  localparam int GW = 8;
  localparam logic [GW-1:0] STRAP_V = 8'h5A;
  localparam logic [31:0] CLK_V = 32'd80_000_000;
  localparam logic [31:0] CAPS_V = 32'h0000_00C3;
  localparam logic [31:0] ID_V = 32'h1001_4D31;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [6:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic err, rst_req, shut_req;
  logic [GW-1:0] pins = 8'hFF, gout;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sys_ctrl_bank #(.GPIO_W(GW), .STRAP(STRAP_V), .CLK_HZ(CLK_V), .CAPS(CAPS_V), .SYS_ID(ID_V)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err), .gpio_in_i(pins),
    .gpio_out_o(gout), .sys_rst_req_o(rst_req), .shutdown_req_o(shut_req));

  function automatic bit is_mapped(int i);
    return i inside {0, 1, 2, 16, 20, 21, 29, 30, 31};
  endfunction

  function automatic logic [31:0] pat(int i);
    return 32'hA500_0000 ^ (i * 32'h0101_0101) ^ 32'h0000_3C00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic do_read(int i, logic [1:0] lsb, output logic [31:0] d, output logic e);
    addr = 7'(i * 4) | 7'(lsb); rd = 1'b1;
    @(negedge clk);
    d = rdata; e = err; rd = 1'b0;
  endtask

  task automatic do_write(int i, logic [31:0] v, output logic e, output logic rq, output logic sq);
    addr = 7'(i * 4); wdata = v; wr = 1'b1;
    @(negedge clk);
    e = err; rq = rst_req; sq = shut_req; wr = 1'b0;
  endtask

  task automatic apply_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, exp;
    logic e, rq, sq;
    pins = 8'hFF;
    @(negedge clk);
    chk("R1 outputs in reset", {gout, 8'h0, 7'h0, err, 6'h0, rst_req, shut_req}, 32'h0);
    apply_reset();
    // R1: pin word still holds the strap at the first access edge
    do_read(0, 2'd0, d, e);
    chk("R1 pin input reset", d, 32'(STRAP_V));
    for (int i = 1; i < 32; i++) begin
      case (i)
        16: exp = 32'h1;
        29: exp = CLK_V;
        30: exp = CAPS_V;
        31: exp = ID_V;
        default: exp = 32'h0;
      endcase
      do_read(i, 2'(i), d, e);   // R2: low address bits vary
      chk("R1 R2 reset read", d, exp);
      chk("R8 error flag on read", 32'(e), 32'(!is_mapped(i)));
    end
    chk("R1 gpio_out_o reset", 32'(gout), 32'h0);
    // R2: data holds after the read strobe drops
    @(negedge clk);
    chk("R2 read data held", rdata, ID_V);

    // R3 R5 R7 R8 R10: write sweep over every index
    for (int i = 0; i < 32; i++) begin
      do_write(i, pat(i), e, rq, sq);
      chk("R8 error flag on write", 32'(e), 32'(!is_mapped(i)));
      chk("R5 R10 reset request", 32'(rq), 32'(i == 31));
      chk("R10 no shutdown", 32'(sq), 32'h0);
      if (i == 1) chk("R3 gpio_out_o", 32'(gout), 32'(pat(1)) & 32'hFF);
      if (i == 31) begin
        @(negedge clk);
        chk("R5 reset request one cycle", 32'(rst_req), 32'h0);
      end
    end
    for (int i = 0; i < 32; i++) begin
      case (i)
        0: exp = 32'hFF;
        1, 2: exp = pat(i) & 32'hFF;
        16: exp = 32'h1;
        20: exp = pat(20);
        21: exp = 32'h1;
        29: exp = CLK_V;
        30: exp = CAPS_V;
        31: exp = ID_V;
        default: exp = 32'h0;
      endcase
      do_read(i, 2'd3, d, e);
      chk("R3 R4 R5 R7 R8 readback", d, exp);
      chk("R10 read raises no request", {30'h0, rst_req, shut_req}, 32'h0);
    end

    // R6: command sweep around the shutdown code
    for (int k = 0; k < 16; k++) begin
      logic [31:0] v;
      v = {16'(k * 16'h1111), 16'(16'h0006 + k)};
      do_write(16, v, e, rq, sq);
      chk("R6 shutdown request", 32'(sq), 32'(v[15:0] == 16'h000E));
      chk("R6 no reset request", 32'(rq), 32'h0);
      @(negedge clk);
      chk("R6 shutdown one cycle", 32'(shut_req), 32'h0);
    end
    do_read(16, 2'd0, d, e);
    chk("R6 command reads ready", d, 32'h1);

    // R4: fresh reset, write zero to lock
    apply_reset();
    do_read(21, 2'd0, d, e);
    chk("R4 lock clear after reset", d, 32'h0);
    do_write(21, 32'h0, e, rq, sq);
    do_read(21, 2'd0, d, e);
    chk("R4 lock set by zero write", d, 32'h1);
    do_write(21, 32'hFFFF_FFFE, e, rq, sq);
    do_read(21, 2'd0, d, e);
    chk("R4 lock stays set", d, 32'h1);

    // R9: two-flop input path
    @(negedge clk);
    pins = 8'h3C;
    do_read(0, 2'd0, d, e);
    do_read(0, 2'd0, d, e);
    chk("R9 old value at second edge", d, 32'hFF);
    do_read(0, 2'd0, d, e);
    chk("R9 new value at third edge", d, 32'h3C);
    do_write(0, 32'h0000_0000, e, rq, sq);
    do_read(0, 2'd0, d, e);
    chk("R7 pin input ignores write", d, 32'h3C);
    chk("R7 no error on read-only write", 32'(e), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule